// File: doc/BRIEF.md
# SECDED Nibble Codec

This block protects a 4-bit data nibble with a single-error-correcting, double-error-detecting Hamming code. Its write path turns a nibble into an 8-bit codeword. The codeword carries three Hamming check bits and one overall parity bit, interleaved with the data at fixed positions. Its read path takes an 8-bit codeword that may have been corrupted in storage. It returns the repaired nibble, the 3-bit syndrome and exactly one of four outcome flags.

The two paths are independent and each has one register stage. A word presented with its valid strobe comes out one clock later with an output valid strobe. Logic around a small storage array uses the block by encoding on the way in and checking on the way out.

Codeword bit k (0..7) holds code position k+1. The positions, from 1 to 8, are c1, c2, d1, c3, d2, d3, d4, p. Data input bit 0 is d1 and bit 3 is d4.

Top module: `secded_codec`

## Requirements
- R1: The check bits are c1 = d1^d2^d4, c2 = d1^d3^d4 and c3 = d2^d3^d4. They are placed at codeword bits 0, 1 and 3, and d1..d4 are placed at bits 2, 4, 5 and 6. For example, data 4'b0110 encodes to 8'h33.
- R2: Codeword bit 7 is the XOR of bits 0 to 6, so every encoded word has even parity over all eight bits.
- R3: Each path's outputs and its valid strobe appear exactly one clock after the input valid. The output valid is low in every other cycle.
- R4: The syndrome output is {s3,s2,s1}, where each si is the received ci XOR ci recomputed from the received data bits. A single flip at position n (1..7) gives syndrome n. For example, flipping d2 of 8'h33 gives 3'b101, and flipping c2 gives 3'b010.
- R5: When the syndrome is zero and the eight received bits have even parity, the no-error flag is set and the data is passed through unchanged.
- R6: When the syndrome is nonzero and the parity is odd, the corrected flag is set and the data bit at the syndrome position, if any, is inverted.
- R7: When the syndrome is nonzero and the parity is even, the uncorrectable flag is set. The received data is passed through unchanged and the corrected flag stays low.
- R8: When the syndrome is zero and the parity is odd, the parity-bit-only flag is set and the data is passed through unchanged.
- R9: A synchronous active-low reset clears both valid outputs and all four flags. While the read valid is high exactly one flag is set, and while it is low all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | Write-path input valid |
| enc_data_i | input | 4 | Nibble to encode, bit 0 = d1 |
| enc_valid_o | output | 1 | Write-path output valid |
| enc_code_o | output | 8 | Encoded codeword |
| dec_valid_i | input | 1 | Read-path input valid |
| dec_code_i | input | 8 | Received codeword |
| dec_valid_o | output | 1 | Read-path output valid |
| dec_data_o | output | 4 | Corrected or passed-through nibble |
| dec_syndrome_o | output | 3 | Syndrome {s3,s2,s1} |
| dec_ok_o | output | 1 | No error found |
| dec_fixed_o | output | 1 | Single error corrected |
| dec_dbl_o | output | 1 | Double error, uncorrectable |
| dec_par_o | output | 1 | Error in overall parity bit only |

## Verification
The hardest outcomes to reach from the ports are the double-error case and the parity-bit-only case. A valid encoder output never produces either one. Two flips can also cancel in the syndrome in ways a casual bench would not notice. The stimulus therefore takes each encoded word and applies zero, one or two flips at positions drawn from $urandom. It includes directed flips of bit 7 alone and of check-bit pairs. Each result is compared against a bench model of the syndrome and parity rules.

// File: rtl/secded_pkg.sv
// Package: shared widths and the Hamming check-bit function for the nibble codec.
// Assumes codeword bit k carries code position k+1.
package secded_pkg;
    localparam int DATA_W = 4;
    localparam int CHK_W  = 3;
    localparam int CODE_W = DATA_W + CHK_W + 1;
    localparam int FLAG_W = 4;

    // Computes {c3,c2,c1} from a nibble whose bit 0 is d1.
    function automatic logic [CHK_W-1:0] chk_bits(input logic [DATA_W-1:0] d);
        chk_bits[0] = d[0] ^ d[1] ^ d[3];
        chk_bits[1] = d[0] ^ d[2] ^ d[3];
        chk_bits[2] = d[1] ^ d[2] ^ d[3];
    endfunction

    // Returns the 1-based code position of data bit i.
    function automatic int data_pos(input int i);
        case (i)
            0: data_pos = 3;
            1: data_pos = 5;
            2: data_pos = 6;
            default: data_pos = 7;
        endcase
    endfunction

    // Returns the 1-based code position of check bit j.
    function automatic int chk_pos(input int j);
        chk_pos = 1 << j;
    endfunction

    // Outcome flags of one read.
    typedef struct packed {
        logic ok;
        logic fixed;
        logic dbl;
        logic par;
    } dec_flags_t;
endpackage

// File: rtl/secded_enc.sv
// Module: combinational encoder. It places the data and check bits at their
// code positions and appends the overall parity bit in the top slot.
// Assumes: pure logic, registered by the caller.
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CHK_W-1:0]  chk;
    logic [CODE_W-2:0] body;

    assign chk = chk_bits(data_i);

    // Scatter data and check bits into the body of the codeword.
    always_comb begin
        body = '0;
        for (int i = 0; i < DATA_W; i++) body[data_pos(i)-1] = data_i[i];
        for (int j = 0; j < CHK_W; j++)  body[chk_pos(j)-1]  = chk[j];
    end

    assign code_o = {^body, body};
endmodule

// File: rtl/secded_dec.sv
// Module: combinational checker. It computes the syndrome and overall parity,
// sorts the word into one of four outcomes and repairs a single data-bit flip.
// Assumes: pure logic, registered by the caller.
module secded_dec
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  syn_o,
    output dec_flags_t        flags_o
);
    logic [DATA_W-1:0] rx_data;
    logic [CHK_W-1:0]  rx_chk;
    logic              par_odd;
    logic              syn_nz;

    // Gather received data and check bits from their positions.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) rx_data[i] = code_i[data_pos(i)-1];
        for (int j = 0; j < CHK_W; j++)  rx_chk[j]  = code_i[chk_pos(j)-1];
    end

    assign syn_o   = rx_chk ^ chk_bits(rx_data);
    assign syn_nz  = |syn_o;
    assign par_odd = ^code_i;

    // Classify the outcome from the syndrome and parity.
    always_comb begin
        flags_o.ok    = !syn_nz && !par_odd;
        flags_o.fixed =  syn_nz &&  par_odd;
        flags_o.dbl   =  syn_nz && !par_odd;
        flags_o.par   = !syn_nz &&  par_odd;
    end

    // Invert the data bit named by the syndrome, only on a single error.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            data_o[i] = rx_data[i] ^ (flags_o.fixed && (int'(syn_o) == data_pos(i)));
    end
endmodule

// File: rtl/secded_codec.sv
// Module: top of the nibble codec. It registers the encoder and the checker,
// each behind its own valid strobe, with one clock of latency.
// Assumes: synchronous active-low reset; outputs hold their last value while
// idle, but the flags are cleared whenever the read valid is low.
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syndrome_o,
    output logic              dec_ok_o,
    output logic              dec_fixed_o,
    output logic              dec_dbl_o,
    output logic              dec_par_o
);
    logic [CODE_W-1:0] enc_code_c;
    logic [DATA_W-1:0] dec_data_c;
    logic [CHK_W-1:0]  dec_syn_c;
    dec_flags_t        dec_flags_c;
    dec_flags_t        flags_q;

    secded_enc u_enc (.data_i(enc_data_i), .code_o(enc_code_c));
    secded_dec u_dec (.code_i(dec_code_i), .data_o(dec_data_c),
                      .syn_o(dec_syn_c), .flags_o(dec_flags_c));

    // Write-path register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid_o <= 1'b0;
            enc_code_o  <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) enc_code_o <= enc_code_c;
        end
    end

    // Read-path register stage; flags are qualified by the input valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o    <= 1'b0;
            dec_data_o     <= '0;
            dec_syndrome_o <= '0;
            flags_q        <= '0;
        end else begin
            dec_valid_o <= dec_valid_i;
            flags_q     <= dec_valid_i ? dec_flags_c : '0;
            if (dec_valid_i) begin
                dec_data_o     <= dec_data_c;
                dec_syndrome_o <= dec_syn_c;
            end
        end
    end

    assign dec_ok_o    = flags_q.ok;
    assign dec_fixed_o = flags_q.fixed;
    assign dec_dbl_o   = flags_q.dbl;
    assign dec_par_o   = flags_q.par;

    AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (^enc_code_o) == 1'b0); // R2
    AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o); // R3
    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o); // R3
    AST_OK_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ok_o |-> dec_syndrome_o == '0); // R5
    AST_DBL_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        dec_dbl_o |-> !dec_fixed_o && dec_syndrome_o != '0); // R7
    AST_PAR_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_par_o |-> dec_syndrome_o == '0); // R8
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> $countones({dec_ok_o, dec_fixed_o, dec_dbl_o, dec_par_o}) == 1); // R9
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> !(dec_ok_o || dec_fixed_o || dec_dbl_o || dec_par_o)); // R9
endmodule

// File: tb/test_secded_codec.sv
module test_secded_codec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enc_valid_i;
    logic [3:0] enc_data_i;
    logic       enc_valid_o;
    logic [7:0] enc_code_o;
    logic       dec_valid_i;
    logic [7:0] dec_code_i;
    logic       dec_valid_o;
    logic [3:0] dec_data_o;
    logic [2:0] dec_syndrome_o;
    logic       dec_ok_o, dec_fixed_o, dec_dbl_o, dec_par_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_codec i_secded_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_syndrome_o(dec_syndrome_o), .dec_ok_o(dec_ok_o),
        .dec_fixed_o(dec_fixed_o), .dec_dbl_o(dec_dbl_o), .dec_par_o(dec_par_o)
    );

    // Reference encoder built from R1 and R2.
    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic c1, c2, c3;
        logic [6:0] b;
        c1 = d[0] ^ d[1] ^ d[3];
        c2 = d[0] ^ d[2] ^ d[3];
        c3 = d[1] ^ d[2] ^ d[3];
        b = {d[3], d[2], d[1], c3, d[0], c2, c1};
        return {^b, b};
    endfunction

    // Reference checker from R4..R8: returns {data, syndrome, ok, fixed, dbl, par}.
    function automatic logic [10:0] ref_dec(input logic [7:0] w);
        logic [3:0] d;
        logic [2:0] s;
        logic [7:0] fixw;
        logic odd;
        logic [3:0] f;
        d = {w[6], w[5], w[4], w[2]};
        s[0] = w[0] ^ (d[0] ^ d[1] ^ d[3]);
        s[1] = w[1] ^ (d[0] ^ d[2] ^ d[3]);
        s[2] = w[3] ^ (d[1] ^ d[2] ^ d[3]);
        odd = ^w;
        fixw = w;
        if (s == 0 && !odd)      f = 4'b1000;
        else if (s != 0 && odd) begin
            f = 4'b0100;
            fixw[s-1] = ~fixw[s-1];
        end
        else if (s != 0)         f = 4'b0010;
        else                     f = 4'b0001;
        return {fixw[6], fixw[5], fixw[4], fixw[2], s, f};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one word on each path at a falling edge and check one clock later.
    task automatic run_enc(input logic [3:0] d, input string req);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        @(negedge clk);
        enc_valid_i = 1'b0;
        chk({req, " R3 enc valid"}, enc_valid_o, 1);
        chk(req, enc_code_o, ref_enc(d));
    endtask

    task automatic run_dec(input logic [7:0] w, input string req);
        logic [10:0] e;
        e = ref_dec(w);
        dec_valid_i = 1'b1;
        dec_code_i  = w;
        @(negedge clk);
        dec_valid_i = 1'b0;
        chk({req, " R3 dec valid"}, dec_valid_o, 1);
        chk({req, " data"}, dec_data_o, e[10:7]);
        chk({req, " R4 syndrome"}, dec_syndrome_o, e[6:4]);
        chk({req, " flags"}, {dec_ok_o, dec_fixed_o, dec_dbl_o, dec_par_o}, e[3:0]);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5ec0ded;
        void'($urandom(seed));
        rst_n = 1'b0;
        enc_valid_i = 1'b1; enc_data_i = 4'hF;
        dec_valid_i = 1'b1; dec_code_i = 8'hFF;
        repeat (3) @(negedge clk);
        // R9: reset clears valids and flags even with inputs valid.
        chk("R9 reset enc valid", enc_valid_o, 0);
        chk("R9 reset dec valid", dec_valid_o, 0);
        chk("R9 reset flags", {dec_ok_o, dec_fixed_o, dec_dbl_o, dec_par_o}, 0);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 directed example.
        run_enc(4'b0110, "R1 example");
        chk("R1 example literal", enc_code_o, 8'h33);
        // R3: valid drops the cycle after.
        @(negedge clk);
        chk("R3 enc idle", enc_valid_o, 0);

        // R5 clean word.
        run_dec(8'h33, "R5 clean");
        chk("R5 clean data literal", dec_data_o, 4'b0110);
        // R4 / R6: flip d2 gives syndrome 5.
        run_dec(8'h33 ^ 8'h10, "R6 flip d2");
        chk("R4 syndrome d2 literal", dec_syndrome_o, 3'b101);
        chk("R6 corrected literal", dec_data_o, 4'b0110);
        // R4: flip c2 gives syndrome 2, data untouched.
        run_dec(8'h33 ^ 8'h02, "R6 flip c2");
        chk("R4 syndrome c2 literal", dec_syndrome_o, 3'b010);
        // R8: parity bit only.
        run_dec(8'h33 ^ 8'h80, "R8 parity only");
        chk("R8 flag literal", dec_par_o, 1);
        chk("R8 data literal", dec_data_o, 4'b0110);
        // R7: two check bits flipped.
        run_dec(8'h33 ^ 8'h03, "R7 c1 c2");
        chk("R7 dbl literal", {dec_dbl_o, dec_fixed_o}, 2'b10);
        chk("R7 passthrough", dec_data_o, 4'b0110);
        // R7: a data bit and the parity bit.
        run_dec(8'h33 ^ 8'h84, "R7 d1 p");
        // R9: flags clear when idle.
        @(negedge clk);
        chk("R9 idle dec valid", dec_valid_o, 0);
        chk("R9 idle flags", {dec_ok_o, dec_fixed_o, dec_dbl_o, dec_par_o}, 0);

        // R2 / R1 exhaustive over all nibbles.
        for (int d = 0; d < 16; d++) begin
            run_enc(d[3:0], "R1 sweep");
            chk("R2 even parity", ^enc_code_o, 0);
        end

        // Random mix of 0, 1 and 2 flips.
        for (int k = 0; k < 400; k++) begin
            logic [3:0] d;
            logic [7:0] w;
            int a, b, nf;
            d  = 4'($urandom);
            w  = ref_enc(d);
            nf = $urandom % 3;
            a  = $urandom % 8;
            b  = (a + 1 + ($urandom % 7)) % 8;
            if (nf >= 1) w[a] = ~w[a];
            if (nf == 2) w[b] = ~w[b];
            run_dec(w, nf == 0 ? "R5 rand" : (nf == 1 ? "R6 rand" : "R7 rand"));
            if (nf < 2) chk("R6 rand original data", dec_data_o, d);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule